// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block is the programmable feedback divider of an integer-N frequency synthesizer. It runs directly on the oscillator-rate clock. For every N cycles of that clock it produces one pulse for the phase detector. The ratio is N = B·P + A, where P is the lower modulus of a two-modulus prescaler. The ratio does not come from one wide binary counter. A small prescaler counts either P or P+1 input cycles. A swallow counter (A) holds it at P+1 for the first A prescaler cycles of each output period. A main counter (B) counts all B prescaler cycles of the period.

A new ratio is written as a prescaler-select code, a swallow value and a main value, and is captured by a load strobe. The captured values wait in a pending stage. The divider adopts them only when the period in progress finishes, so an update never produces a period that is cut short or stretched. A request with B smaller than A, or with B equal to zero, cannot be divided correctly. Such a request is refused, an error output is raised, and the divider keeps its last valid ratio.

Top module: `fbdiv_dual_modulus`

## Requirements
- R1: While reset is low, `fb_pulse` and `ratio_err` are 0. After reset is released, the divider uses the reset ratio (select 2'b00, A = 1, B = 4, N = 33), and the first pulse appears after the 33rd rising clock edge.
- R2: With select code 2'b00 (P = 8, prescaler 8/9), consecutive pulses are exactly B·8 + A input cycles apart.
- R3: With select code 2'b01 (P = 16, prescaler 16/17), consecutive pulses are exactly B·16 + A input cycles apart.
- R4: With select code 2'b10 or 2'b11 (P = 32, prescaler 32/33), consecutive pulses are exactly B·32 + A input cycles apart.
- R5: Each output pulse is high for exactly one input clock cycle.
- R6: A ratio captured by `ratio_load` during a period does not change the length of that period. It sets the length of every period that starts after the next pulse.
- R7: When several valid loads arrive within one period, only the last one takes effect at the next boundary.
- R8: A load with B < A, or with B = 0, is refused. `ratio_err` is 1 from the cycle after that load, and the pulse spacing stays at the last valid ratio.
- R9: `ratio_err` returns to 0 in the cycle after the next valid load, and that load's ratio then applies from the next boundary.
- R10: The edge cases B = A (every prescaler cycle at P+1) and A = 0 (every prescaler cycle at P) both give N = B·P + A.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Oscillator-rate input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_sel | input | 2 | Prescaler select: 00 = 8/9, 01 = 16/17, 10/11 = 32/33 |
| swallow_val | input | A_W (5) | Requested swallow count A |
| main_val | input | B_W (13) | Requested main count B |
| ratio_load | input | 1 | Captures mod_sel, swallow_val and main_val on a rising edge |
| fb_pulse | output | 1 | One-cycle pulse at the end of each N-cycle period |
| ratio_err | output | 1 | High after a refused load (B < A or B = 0), until the next valid load |

## Verification
Almost every internal fault shows up as wrong spacing between pulses. A swallow count that is stuck, a prescaler counter that wraps one cycle early, or a select code that is decoded wrongly all move the next pulse by one or more input cycles. That error can be seen no later than the first full period after the fault. A fault in the pending stage that applies a ratio early or late changes the length of the period that contains the load, or of the period after it, so it shows within two pulses of the strobe. A wrongly accepted invalid request shows one cycle after its strobe on `ratio_err`, and it changes the spacing of the next period.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  typedef enum logic [1:0] {
    PSEL_8  = 2'b00,
    PSEL_16 = 2'b01,
    PSEL_32 = 2'b10,
    PSEL_32X = 2'b11
  } psel_e;

  // Lower prescaler modulus P for a select code, with the smallest
  // modulus equal to 2**base_log2.
  function automatic int unsigned base_modulus(input logic [1:0] sel,
                                               input int unsigned base_log2);
    int unsigned step;
    case (psel_e'(sel))
      PSEL_8:  step = 0;
      PSEL_16: step = 1;
      default: step = 2;
    endcase
    return 32'd1 << (base_log2 + step);
  endfunction

  // Total division ratio N = B*P + A.
  function automatic int unsigned ratio_of(input logic [1:0] sel,
                                           input int unsigned a,
                                           input int unsigned b,
                                           input int unsigned base_log2);
    return b * base_modulus(sel, base_log2) + a;
  endfunction

  // A request can be divided only when the main count covers the swallow count.
  function automatic logic ratio_ok(input int unsigned a, input int unsigned b);
    return (b != 0) && (b >= a);
  endfunction

endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
  import fbdiv_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 13,
  parameter logic [1:0] RST_SEL = 2'b00,
  parameter int RST_A = 1,
  parameter int RST_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [1:0]     sel_in,
  input  logic [A_W-1:0] a_in,
  input  logic [B_W-1:0] b_in,
  input  logic           take,
  output logic [1:0]     act_sel,
  output logic [A_W-1:0] act_a,
  output logic [B_W-1:0] act_b,
  output logic [1:0]     nxt_sel,
  output logic [A_W-1:0] nxt_a,
  output logic [B_W-1:0] nxt_b,
  output logic           ratio_err
);

  logic           req_ok;
  logic           load_ok;
  logic           load_bad;
  logic           pend_valid;
  logic [1:0]     pend_sel;
  logic [A_W-1:0] pend_a;
  logic [B_W-1:0] pend_b;

  assign req_ok   = ratio_ok(int'(a_in), int'(b_in));
  assign load_ok  = load && req_ok;
  assign load_bad = load && !req_ok;

  // Values that the next period will run with.
  always_comb begin
    if (pend_valid) begin
      nxt_sel = pend_sel;
      nxt_a   = pend_a;
      nxt_b   = pend_b;
    end else begin
      nxt_sel = act_sel;
      nxt_a   = act_a;
      nxt_b   = act_b;
    end
  end

  // Pending stage: the last valid request wins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_sel   <= RST_SEL;
      pend_a     <= A_W'(RST_A);
      pend_b     <= B_W'(RST_B);
    end else if (load_ok) begin
      pend_valid <= 1'b1;
      pend_sel   <= sel_in;
      pend_a     <= a_in;
      pend_b     <= b_in;
    end else if (take) begin
      pend_valid <= 1'b0;
    end
  end

  // Active stage: changes only at a period boundary.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= RST_SEL;
      act_a   <= A_W'(RST_A);
      act_b   <= B_W'(RST_B);
    end else if (take) begin
      act_sel <= nxt_sel;
      act_a   <= nxt_a;
      act_b   <= nxt_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ratio_err <= 1'b0;
    end else if (load) begin
      ratio_err <= load_bad;
    end
  end

  AST_REFUSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> ratio_err); // R8

  AST_ACCEPT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !ratio_err); // R9

  AST_REFUSE_KEEPS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    load_bad |=> ($stable(pend_a) && $stable(pend_b) && $stable(pend_sel))); // R8

  AST_ACTIVE_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(act_a) && $stable(act_b) && $stable(act_sel))); // R6

  AST_ACTIVE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_ok(int'(act_a), int'(act_b))); // R8

endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int PC_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] modulus,
  output logic            pre_end
);

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] last_pos;

  assign last_pos = modulus - PC_W'(1);
  assign pre_end  = (pc == last_pos);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0;
    end else if (pre_end) begin
      pc <= '0;
    end else begin
      pc <= pc + PC_W'(1);
    end
  end

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pc < modulus); // R2

  AST_PC_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    pre_end |=> (pc == '0)); // R3

endmodule

// File: rtl/fbdiv_counters.sv
module fbdiv_counters #(
  parameter int A_W = 5,
  parameter int B_W = 13,
  parameter int RST_A = 1,
  parameter int RST_B = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_end,
  input  logic [A_W-1:0] ld_a,
  input  logic [B_W-1:0] ld_b,
  output logic           swallow_on,
  output logic           period_end
);

  logic [A_W-1:0] a_rem;
  logic [B_W-1:0] b_rem;
  logic           last_pre;

  assign swallow_on = (a_rem != '0);
  assign last_pre   = (b_rem == B_W'(1));
  assign period_end = pre_end && last_pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem <= A_W'(RST_A);
      b_rem <= B_W'(RST_B);
    end else if (period_end) begin
      a_rem <= ld_a;
      b_rem <= ld_b;
    end else if (pre_end) begin
      b_rem <= b_rem - B_W'(1);
      if (swallow_on) begin
        a_rem <= a_rem - A_W'(1);
      end
    end
  end

  AST_SWALLOW_WITHIN_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    int'(a_rem) <= int'(b_rem)); // R10

  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    b_rem != '0); // R8

  AST_SWALLOW_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |-> (a_rem <= A_W'(1))); // R10

endmodule

// File: rtl/fbdiv_dual_modulus.sv
module fbdiv_dual_modulus
  import fbdiv_pkg::*;
#(
  parameter int A_W = 5,
  parameter int B_W = 13,
  parameter int BASE_LOG2 = 3,
  parameter logic [1:0] RST_SEL = 2'b00,
  parameter int RST_A = 1,
  parameter int RST_B = 4
) (
  input  logic           clk_vco,
  input  logic           rst_n,
  input  logic [1:0]     mod_sel,
  input  logic [A_W-1:0] swallow_val,
  input  logic [B_W-1:0] main_val,
  input  logic           ratio_load,
  output logic           fb_pulse,
  output logic           ratio_err
);

  localparam int MAX_MOD = (1 << (BASE_LOG2 + 2)) + 1;
  localparam int PC_W    = $clog2(MAX_MOD + 1);

  logic [1:0]     act_sel;
  logic [A_W-1:0] act_a;
  logic [B_W-1:0] act_b;
  logic [1:0]     nxt_sel;
  logic [A_W-1:0] nxt_a;
  logic [B_W-1:0] nxt_b;
  logic           swallow_on;
  logic           pre_end;
  logic           period_end;
  logic [PC_W-1:0] cur_mod;

  fbdiv_cfg #(
    .A_W(A_W), .B_W(B_W), .RST_SEL(RST_SEL), .RST_A(RST_A), .RST_B(RST_B)
  ) u_cfg (
    .clk(clk_vco), .rst_n(rst_n), .load(ratio_load),
    .sel_in(mod_sel), .a_in(swallow_val), .b_in(main_val),
    .take(period_end),
    .act_sel(act_sel), .act_a(act_a), .act_b(act_b),
    .nxt_sel(nxt_sel), .nxt_a(nxt_a), .nxt_b(nxt_b),
    .ratio_err(ratio_err)
  );

  // Prescaler runs at P+1 while swallow cycles remain, otherwise at P.
  assign cur_mod = PC_W'(base_modulus(act_sel, BASE_LOG2)) + PC_W'(swallow_on);

  fbdiv_prescaler #(.PC_W(PC_W)) u_pre (
    .clk(clk_vco), .rst_n(rst_n), .modulus(cur_mod), .pre_end(pre_end)
  );

  fbdiv_counters #(
    .A_W(A_W), .B_W(B_W), .RST_A(RST_A), .RST_B(RST_B)
  ) u_cnt (
    .clk(clk_vco), .rst_n(rst_n), .pre_end(pre_end),
    .ld_a(nxt_a), .ld_b(nxt_b),
    .swallow_on(swallow_on), .period_end(period_end)
  );

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) begin
      fb_pulse <= 1'b0;
    end else begin
      fb_pulse <= period_end;
    end
  end

  // Independent period-length monitor for the assertions.
  logic [31:0] per_cnt;
  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) begin
      per_cnt <= '0;
    end else if (period_end) begin
      per_cnt <= '0;
    end else begin
      per_cnt <= per_cnt + 32'd1;
    end
  end

  AST_PERIOD_LENGTH: assert property (@(posedge clk_vco) disable iff (!rst_n)
    period_end |-> (per_cnt + 32'd1 == ratio_of(act_sel, int'(act_a), int'(act_b), BASE_LOG2))); // R2

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_vco) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse); // R5

  AST_PULSE_AFTER_END: assert property (@(posedge clk_vco) disable iff (!rst_n)
    period_end |=> fb_pulse); // R5

  AST_RESET_QUIET: assert property (@(posedge clk_vco)
    !rst_n |-> (!fb_pulse && !ratio_err)); // R1

endmodule

// File: tb/sim_fbdiv_dual_modulus.sv
`timescale 1ns/1ps
module sim_fbdiv_dual_modulus;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mod_sel = 2'b00;
  logic [4:0]  swallow_val = '0;
  logic [12:0] main_val = '0;
  logic        ratio_load = 1'b0;
  logic        fb_pulse;
  logic        ratio_err;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int cur_n = 0;
  int last_t = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fbdiv_dual_modulus u0 (
    .clk_vco(clk), .rst_n(rst_n), .mod_sel(mod_sel),
    .swallow_val(swallow_val), .main_val(main_val),
    .ratio_load(ratio_load), .fb_pulse(fb_pulse), .ratio_err(ratio_err)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  function automatic int expect_n(input int sel, input int a, input int b);
    int p;
    p = (sel == 0) ? 8 : ((sel == 1) ? 16 : 32);
    return b * p + a;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_pulse(output int t);
    do @(negedge clk); while (!fb_pulse);
    t = cyc;
  endtask

  // Called at the negedge where a pulse was seen; strobe lands mid-period.
  task automatic apply(input int sel, input int a, input int b);
    mod_sel = 2'(sel);
    swallow_val = 5'(a);
    main_val = 13'(b);
    ratio_load = 1'b1;
    @(negedge clk);
    ratio_load = 1'b0;
  endtask

  task automatic t_reset();
    int t;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!fb_pulse && !ratio_err, "R1 outputs low in reset", int'(fb_pulse), 0);
    end
    rst_n = 1'b1;
    wait_pulse(t);
    chk(t == 33, "R1 first pulse after reset", t, 33);
    chk(!ratio_err, "R1 no error after reset", int'(ratio_err), 0);
    last_t = t;
    wait_pulse(t);
    chk(t - last_t == 33, "R1 reset ratio spacing", t - last_t, 33);
    last_t = t;
    cur_n = 33;
  endtask

  task automatic t_ratio(input int sel, input int a, input int b, input string tag);
    int t1, t2, t3, n;
    n = expect_n(sel, a, b);
    apply(sel, a, b);
    chk(!ratio_err, "R9 valid load leaves error low", int'(ratio_err), 0);
    wait_pulse(t1);
    chk(t1 - last_t == cur_n, "R6 period with load unchanged", t1 - last_t, cur_n);
    wait_pulse(t2);
    chk(t2 - t1 == n, tag, t2 - t1, n);
    @(negedge clk);
    chk(!fb_pulse, "R5 pulse one cycle wide", int'(fb_pulse), 0);
    wait_pulse(t3);
    chk(t3 - t2 == n, tag, t3 - t2, n);
    cur_n = n;
    last_t = t3;
  endtask

  task automatic t_multi();
    int t1, t2, n;
    n = expect_n(1, 5, 6);
    mod_sel = 2'd0; swallow_val = 5'd2; main_val = 13'd20; ratio_load = 1'b1;
    @(negedge clk);
    mod_sel = 2'd1; swallow_val = 5'd5; main_val = 13'd6;
    @(negedge clk);
    ratio_load = 1'b0;
    wait_pulse(t1);
    chk(t1 - last_t == cur_n, "R7 current period unchanged", t1 - last_t, cur_n);
    wait_pulse(t2);
    chk(t2 - t1 == n, "R7 last load wins", t2 - t1, n);
    cur_n = n;
    last_t = t2;
  endtask

  task automatic t_refuse(input int a, input int b);
    int t1, t2;
    apply(0, a, b);
    chk(ratio_err, "R8 error raised on refused load", int'(ratio_err), 1);
    wait_pulse(t1);
    chk(t1 - last_t == cur_n, "R8 ratio held (1st)", t1 - last_t, cur_n);
    wait_pulse(t2);
    chk(t2 - t1 == cur_n, "R8 ratio held (2nd)", t2 - t1, cur_n);
    chk(ratio_err, "R8 error stays high", int'(ratio_err), 1);
    last_t = t2;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ratio(0, 3, 5, "R2 8/9 spacing");
    t_ratio(1, 7, 9, "R3 16/17 spacing");
    t_ratio(2, 2, 4, "R4 32/33 spacing sel 10");
    t_ratio(3, 31, 40, "R4 32/33 spacing sel 11");
    t_ratio(0, 6, 6, "R10 B equal A");
    t_ratio(1, 0, 3, "R10 A zero");
    t_multi();
    t_refuse(9, 4);
    t_refuse(0, 0);
    t_ratio(2, 1, 3, "R9 valid load after error applies");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule